// File: doc/BRIEF.md
# External Interrupt Controller

This block gathers eight external interrupt pins into one request for a CPU core. Each pin first passes through a two-flop synchronizer. A per-pin sense mode then decides what counts as activity: a low level, any change, a falling edge or a rising edge. In the three edge modes a detected event sets a pending flag. The flag stays set until the CPU takes that source's vector or software writes a one to it. In level mode the flag is held at zero, and the synchronized low level drives the request directly.

A byte-wide register bus gives software access to three things: the enable mask, the flag register and the sense configuration. A source reaches the request line only when its enable bit and the global interrupt-enable input are both one. When several sources are pending, the lowest-numbered one wins, and its index is presented alongside the request. The CPU pulses an acknowledge when it takes the vector, and that pulse clears the winning source's flag. Because the pins are sampled whatever drives them, software can force an interrupt by driving the pin itself.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the mask (address 0), the flags (address 1) and both sense bytes (addresses 2 and 3) read 0x00, and `irq_o` is low. The synchronizer resets to high, so pins held high through reset set no flag.
- R2: A write stores `bus_wdata_i` at `bus_addr_i`. Address 0 is the mask, where bit i enables source i. Addresses 2 and 3 hold the sense mode of pin i in bits [2i+1:2i] of the 16-bit value formed as {address 3, address 2}. Each of these registers reads back the value written.
- R3: `irq_o` is one only if some source is pending, its mask bit is one, and `gie_i` is one. `irq_o` is low whenever `gie_i` is low.
- R4: In sense mode 2'b11 (rising), a 0-to-1 change on the pin sets its flag three rising clock edges after the change, and a 1-to-0 change does not set it.
- R5: In sense mode 2'b10 (falling), a 1-to-0 change sets the flag, and a 0-to-1 change does not.
- R6: In sense mode 2'b01 (any change), both directions set the flag.
- R7: An edge event sets the flag whether or not the source's mask bit is one.
- R8: Writing to address 1 clears each flag whose data bit is one and leaves flags whose data bit is zero unchanged.
- R9: An `ack_i` pulse while `irq_o` is high clears only the flag of the source shown on `irq_idx_o`.
- R10: In sense mode 2'b00 (level low) the flag always reads zero. The request is asserted two clock edges after the pin goes low and stays asserted while the pin is low. It drops two edges after the pin returns high.
- R11: When several enabled sources are pending, `irq_idx_o` gives the lowest-numbered one.
- R12: If an edge event and a write-one-to-clear of the same flag take effect on the same clock edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational from the address) |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | CPU takes the vector of `irq_idx_o` |
| irq_o | output | 1 | Interrupt request |
| irq_idx_o | output | 3 | Index of the winning source |

## Verification
The assertions take `ack_i` to be a single-cycle pulse that is only raised while `irq_o` is high. They also assume a pin holds each new value for at least three clock cycles, so every change is seen as exactly one event by the synchronizer. The bench drives pins, bus writes and acknowledges on the falling clock edge and holds each pin level for several cycles. It pulses acknowledge only after it has confirmed that a request is pending. For the same-edge case it times the clear write against the known three-edge synchronizer latency.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SNS_LEVEL_LOW = 2'b00,
    SNS_ANY       = 2'b01,
    SNS_FALL      = 2'b10,
    SNS_RISE      = 2'b11
  } sense_e;

  localparam int unsigned NSRC = 8;
  localparam int unsigned IDXW = $clog2(NSRC);

  localparam logic [1:0] ADR_MASK  = 2'd0;
  localparam logic [1:0] ADR_FLAG  = 2'd1;
  localparam logic [1:0] ADR_SNS_L = 2'd2;
  localparam logic [1:0] ADR_SNS_H = 2'd3;

  // Lowest set bit wins; the scan runs downward so the last hit is the lowest.
  function automatic logic [IDXW-1:0] lowest_idx(input logic [NSRC-1:0] vec);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vec[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  // Does this sense mode fire on a (prev -> cur) transition?
  function automatic logic edge_match(input sense_e m, input logic prev, input logic cur);
    logic r;
    case (m)
      SNS_ANY:  r = prev ^ cur;
      SNS_FALL: r = prev & ~cur;
      SNS_RISE: r = ~prev & cur;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  // Reset to high: idle pins are pulled up, so no false edge after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned W = NSRC
) (
  input  logic [W-1:0]   sync_i,
  input  logic [W-1:0]   prev_i,
  input  logic [2*W-1:0] sense_i,
  output logic [W-1:0]   hit_o,
  output logic [W-1:0]   lvl_act_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    sense_e mode;
    assign mode         = sense_e'(sense_i[2*g+1:2*g]);
    assign hit_o[g]     = edge_match(mode, prev_i[g], sync_i[g]);
    assign lvl_act_o[g] = (mode == SNS_LEVEL_LOW) && !sync_i[g];
  end
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned W = NSRC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [1:0]     addr_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  input  logic [W-1:0]   hit_i,
  input  logic [W-1:0]   ack_clr_i,
  output logic [W-1:0]   mask_o,
  output logic [2*W-1:0] sense_o,
  output logic [W-1:0]   flag_o,
  output logic [W-1:0]   level_o
);
  logic [W-1:0]   mask_q, flag_q, flag_d;
  logic [2*W-1:0] sense_q, sense_d;
  logic [W-1:0]   level_d, hit_eff, w1c, clr_all;

  always_comb begin
    sense_d = sense_q;
    if (wr_i && addr_i == ADR_SNS_L) sense_d[W-1:0]   = wdata_i;
    if (wr_i && addr_i == ADR_SNS_H) sense_d[2*W-1:W] = wdata_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_lvl
    assign level_d[g] = (sense_d[2*g+1:2*g] == SNS_LEVEL_LOW);
    assign level_o[g] = (sense_q[2*g+1:2*g] == SNS_LEVEL_LOW);
  end

  assign hit_eff = hit_i & ~level_d;
  assign w1c     = (wr_i && addr_i == ADR_FLAG) ? wdata_i : '0;
  assign clr_all = w1c | ack_clr_i;
  // A set on the same edge beats any clear (R12); level mode forces zero (R10).
  assign flag_d  = ((flag_q & ~clr_all) | hit_eff) & ~level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      sense_q <= '0;
      flag_q  <= '0;
    end else begin
      if (wr_i && addr_i == ADR_MASK) mask_q <= wdata_i;
      sense_q <= sense_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    case (addr_i)
      ADR_MASK:  rdata_o = mask_q;
      ADR_FLAG:  rdata_o = flag_q;
      ADR_SNS_L: rdata_o = sense_q[W-1:0];
      default:   rdata_o = sense_q[2*W-1:W];
    endcase
  end

  assign mask_o  = mask_q;
  assign sense_o = sense_q;
  assign flag_o  = flag_q;

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_eff) |=> ((flag_q & $past(hit_eff)) == $past(hit_eff))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|w1c) |=> ((flag_q & $past(w1c & ~hit_eff)) == '0)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_clr_i) |=> ((flag_q & $past(ack_clr_i & ~hit_eff)) == '0)); // R9
  AST_NO_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(hit_eff)) == '0)); // R7
endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio
  import ext_irq_pkg::*;
#(
  parameter int unsigned W = NSRC
) (
  input  logic [W-1:0]    req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  assign any_o = |req_i;
  assign idx_o = lowest_idx(req_i);

  always_comb begin
    if (any_o) begin
      AST_WIN_IS_LOWEST: assert (req_i[idx_o] && ((req_i & ((W'(1) << idx_o) - W'(1))) == '0)); // R11
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pin_i,
  input  logic            bus_wr_i,
  input  logic [1:0]      bus_addr_i,
  input  logic [NSRC-1:0] bus_wdata_i,
  output logic [NSRC-1:0] bus_rdata_o,
  input  logic            gie_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [IDXW-1:0] irq_idx_o
);
  logic [NSRC-1:0]   sync_w, prev_w, hit_w, lvl_act_w;
  logic [NSRC-1:0]   mask_w, flag_w, level_w, pending_w, req_w, ack_clr_w;
  logic [2*NSRC-1:0] sense_w;
  logic              any_w;
  logic [IDXW-1:0]   idx_w;

  ext_irq_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sync_o(sync_w), .prev_o(prev_w)
  );

  ext_irq_detect #(.W(NSRC)) u_det (
    .sync_i(sync_w), .prev_i(prev_w), .sense_i(sense_w),
    .hit_o(hit_w), .lvl_act_o(lvl_act_w)
  );

  ext_irq_regs #(.W(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .hit_i(hit_w),
    .ack_clr_i(ack_clr_w), .mask_o(mask_w), .sense_o(sense_w),
    .flag_o(flag_w), .level_o(level_w)
  );

  assign pending_w = (flag_w & ~level_w) | lvl_act_w;
  assign req_w     = pending_w & mask_w & {NSRC{gie_i}};

  ext_irq_prio #(.W(NSRC)) u_prio (
    .req_i(req_w), .any_o(any_w), .idx_o(idx_w)
  );

  assign irq_o     = any_w;
  assign irq_idx_o = idx_w;
  assign ack_clr_w = (ack_i && any_w) ? (NSRC'(1) << idx_w) : '0;

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_i); // R3
  AST_IRQ_SOURCE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_w[irq_idx_o] && pending_w[irq_idx_o])); // R3
  AST_LEVEL_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_w & level_w) == '0)); // R10
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr_w)); // R9
endmodule

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = 8'hFF;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       gie = 1'b0;
  logic       ack = 1'b0;
  logic       irq;
  logic [2:0] idx;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .gie_i(gie), .ack_i(ack),
    .irq_o(irq), .irq_idx_o(idx)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic setpin(input int p, input logic v);
    @(negedge clk); pin[p] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all;
    wreg(2'd1, 8'hFF);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rreg(2'(a), d); check("R1 reg", d, 0);
    end
    check("R1 irq", irq, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wreg(2'd0, 8'hA5); rreg(2'd0, d); check("R2 mask", d, 8'hA5);
    wreg(2'd2, 8'h6C); rreg(2'd2, d); check("R2 sns lo", d, 8'h6C);
    wreg(2'd3, 8'h93); rreg(2'd3, d); check("R2 sns hi", d, 8'h93);
    wreg(2'd0, 8'h00); wreg(2'd2, 8'h00); wreg(2'd3, 8'h00);
  endtask

  // pin 1 rising (sns lo bits 3:2 = 11), mask off -> R7
  task automatic t_rise;
    logic [7:0] d;
    wreg(2'd2, 8'b0000_1100);
    setpin(1, 1'b0); rreg(2'd1, d); check("R4 fall ignored", d, 0);
    @(negedge clk); pin[1] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); check("R4 not yet", rdata & 8'h02, 0);
    @(posedge clk); @(negedge clk);
    addr = 2'd1; #1 check("R4 rise at 3rd edge", rdata, 8'h02);
    check("R7 set while masked", irq, 0);
    clear_all; wreg(2'd2, 8'h00);
  endtask

  // pin 4 falling (sns hi bits 1:0 = 10)
  task automatic t_fall;
    logic [7:0] d;
    wreg(2'd3, 8'b0000_0010);
    setpin(4, 1'b0); rreg(2'd1, d); check("R5 fall sets", d, 8'h10);
    clear_all;
    setpin(4, 1'b1); rreg(2'd1, d); check("R5 rise ignored", d, 0);
    wreg(2'd3, 8'h00);
  endtask

  // pin 6 any change (sns hi bits 5:4 = 01); W1C behaviour
  task automatic t_any_w1c;
    logic [7:0] d;
    wreg(2'd3, 8'b0001_0000);
    setpin(6, 1'b0); rreg(2'd1, d); check("R6 fall sets", d, 8'h40);
    wreg(2'd1, 8'hBF); rreg(2'd1, d); check("R8 zero bit keeps", d, 8'h40);
    wreg(2'd1, 8'h40); rreg(2'd1, d); check("R8 one bit clears", d, 0);
    setpin(6, 1'b1); rreg(2'd1, d); check("R6 rise sets", d, 8'h40);
    // R12: new edge lands on the same clock edge as the clear write
    @(negedge clk); pin[6] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr = 1'b1; addr = 2'd1; wdata = 8'h40;
    @(negedge clk); wr = 1'b0;
    rreg(2'd1, d); check("R12 set beats clear", d, 8'h40);
    clear_all; setpin(6, 1'b1); clear_all; wreg(2'd3, 8'h00);
  endtask

  // pins 2 and 5 rising, gating, priority and ack
  task automatic t_prio_ack;
    logic [7:0] d;
    wreg(2'd2, 8'b0011_0000); wreg(2'd3, 8'b0000_1100);
    setpin(2, 1'b0); setpin(5, 1'b0); clear_all;
    setpin(5, 1'b1); setpin(2, 1'b1);
    wreg(2'd0, 8'h24); gie = 1'b0;
    @(negedge clk); check("R3 gie low", irq, 0);
    gie = 1'b1; wreg(2'd0, 8'h20);
    @(negedge clk); check("R3 only 5", {irq, idx}, {1'b1, 3'd5});
    wreg(2'd0, 8'h24);
    @(negedge clk); check("R11 lowest wins", {irq, idx}, {1'b1, 3'd2});
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    rreg(2'd1, d); check("R9 ack clears 2", d, 8'h20);
    check("R9 next idx", {irq, idx}, {1'b1, 3'd5});
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    rreg(2'd1, d); check("R9 ack clears 5", d, 0);
    check("R3 none pending", irq, 0);
    wreg(2'd0, 8'h00); wreg(2'd2, 8'h00); wreg(2'd3, 8'h00);
  endtask

  // pin 0 level low, mode 00
  task automatic t_level;
    logic [7:0] d;
    wreg(2'd0, 8'h01); gie = 1'b1;
    @(negedge clk); pin[0] = 1'b0;
    @(posedge clk); @(negedge clk); check("R10 not yet", irq, 0);
    @(posedge clk); @(negedge clk); check("R10 asserted", {irq, idx}, {1'b1, 3'd0});
    repeat (5) @(negedge clk);
    check("R10 held", irq, 1);
    rreg(2'd1, d); check("R10 flag zero", d, 0);
    pin[0] = 1'b1;
    @(posedge clk); @(negedge clk); check("R10 still", irq, 1);
    @(posedge clk); @(negedge clk); check("R10 released", irq, 0);
    wreg(2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_rise;
    t_fall;
    t_any_w1c;
    t_prio_ack;
    t_level;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule